// File: doc/BRIEF.md
# GPIO Bank Output Register Block with Half-Bank Masked Writes

This block holds the configuration and output state of one 32-pin general purpose I/O bank. It sits on a simple register bus with a word address, a write strobe, write data and read data. It drives one output value and one tristate enable per pin, and it brings the pin levels back through a synchroniser so that software can read them.

The main feature is a pair of masked-write words. Each one covers half the bank. The upper 16 bits of the written word select which pins are protected, and the lower 16 bits carry new levels for that half. Software can therefore change any subset of up to 16 outputs with one bus write, without a read-modify-write sequence that could race with another writer. A pin is driven only when its direction bit and its drive-enable bit are both set.

Reads are combinational from the address. Writes take effect at the rising clock edge on which `wr_en` is high.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the output data, direction and drive-enable registers are all 0, so every `pin_out` and `pin_oe` bit is 0.
- R2: A write to word address 0 loads all 32 output data bits from `wdata`. `pin_out` always equals the output data register, whatever the enables, and address 0 reads back that register.
- R3: A write to word address 1 updates pins 0 to 15. For each bit i in 0..15, the new value is `wdata[i]` where `wdata[16+i]` is 0, and the old value is kept where `wdata[16+i]` is 1. Pins 16 to 31 do not change.
- R4: A write to word address 2 updates pins 16 to 31 in the same way, using `wdata[i]` as data and `wdata[16+i]` as mask for pin 16+i. Pins 0 to 15 do not change.
- R5: Word address 3 is the direction register, one bit per pin, with 1 meaning output. It is written whole and reads back what was written.
- R6: Word address 4 is the drive-enable register, one bit per pin. It is written whole and reads back what was written.
- R7: `pin_oe[i]` is 1 exactly when direction bit i and drive-enable bit i are both 1.
- R8: Word address 5 reads the pin levels through a two-stage synchroniser. A change on `pin_in` that is stable before a rising edge k is visible on `rdata` after edge k+1, and is not yet visible after edge k.
- R9: Writes to address 5 and to the unmapped addresses 6 and 7 change no register. Reads of addresses 1, 2, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value for each pin |
| pin_oe | output | 32 | Tristate enable for each pin, 1 = drive |

## Verification
The bench sends random masked words to both half-bank addresses, including all-zero masks (a full half overwrite) and all-one masks (no change). A design with the mask sense inverted, or one that writes the wrong half, leaves the output register out of step with the bench's per-bit model. Directed pairs of direction and drive-enable values catch an enable gated by only one of the two bits. The pin readback is sampled one edge and two edges after a change, so a synchroniser with one stage too few or too many is seen. Writes to the read-only and unmapped addresses are followed by full readback, which exposes any decode that aliases onto a real register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 32;

  localparam int A_DATA  = 0;
  localparam int A_MLO   = 1;
  localparam int A_MHI   = 2;
  localparam int A_DIR   = 3;
  localparam int A_OEN   = 4;
  localparam int A_PINS  = 5;

  // Apply a masked-write word to one half bank: a mask bit of 1 keeps the pin.
  function automatic logic [HALF_W-1:0] apply_masked(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] word
  );
    logic [HALF_W-1:0] keep;
    keep = word[WORD_W-1:HALF_W];
    return (cur & keep) | (word[HALF_W-1:0] & ~keep);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_full,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [PINS-1:0] data_q
);
  localparam int HI_LSB = PINS - HALF_W;

  logic [PINS-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (wr_full) begin
      data_d = wdata[PINS-1:0];
    end else if (wr_lo) begin
      data_d[HALF_W-1:0] = apply_masked(data_q[HALF_W-1:0], wdata);
    end else if (wr_hi) begin
      data_d[PINS-1:HI_LSB] = apply_masked(data_q[PINS-1:HI_LSB], wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> data_q[PINS-1:HI_LSB] == $past(data_q[PINS-1:HI_LSB]));
  // R3
  lo_mask_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ((data_q[HALF_W-1:0] ^ $past(data_q[HALF_W-1:0]))
               & $past(wdata[WORD_W-1:HALF_W])) == '0);
  // R4
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> data_q[HALF_W-1:0] == $past(data_q[HALF_W-1:0]));
  // R4
  hi_mask_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ((data_q[PINS-1:HI_LSB] ^ $past(data_q[PINS-1:HI_LSB]))
               & $past(wdata[WORD_W-1:HALF_W])) == '0);
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int PINS = 32
) (
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] oen_q,
  output logic [PINS-1:0] pin_oe
);
  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      assign pin_oe[i] = dir_q[i] & oen_q[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  // Named decode events, used by the logic and by the assertions.
  logic sel_data, sel_mlo, sel_mhi, sel_dir, sel_oen, sel_pins;
  logic wr_data_evt, wr_mlo_evt, wr_mhi_evt, wr_dir_evt, wr_oen_evt;
  logic wr_dead_evt;

  logic [PINS-1:0] data_q, dir_q, oen_q, pins_sync;

  assign sel_data = (addr == ADDR_W'(A_DATA));
  assign sel_mlo  = (addr == ADDR_W'(A_MLO));
  assign sel_mhi  = (addr == ADDR_W'(A_MHI));
  assign sel_dir  = (addr == ADDR_W'(A_DIR));
  assign sel_oen  = (addr == ADDR_W'(A_OEN));
  assign sel_pins = (addr == ADDR_W'(A_PINS));

  assign wr_data_evt = wr_en & sel_data;
  assign wr_mlo_evt  = wr_en & sel_mlo;
  assign wr_mhi_evt  = wr_en & sel_mhi;
  assign wr_dir_evt  = wr_en & sel_dir;
  assign wr_oen_evt  = wr_en & sel_oen;
  assign wr_dead_evt = wr_en & ~(sel_data | sel_mlo | sel_mhi | sel_dir | sel_oen);

  gpio_out_data #(.PINS(PINS)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_full(wr_data_evt),
    .wr_lo  (wr_mlo_evt),
    .wr_hi  (wr_mhi_evt),
    .wdata  (wdata),
    .data_q (data_q)
  );

  gpio_cfg_reg #(.W(PINS)) u_dir (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_dir_evt),
    .d    (wdata[PINS-1:0]),
    .q    (dir_q)
  );

  gpio_cfg_reg #(.W(PINS)) u_oen (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_oen_evt),
    .d    (wdata[PINS-1:0]),
    .q    (oen_q)
  );

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pins_sync)
  );

  gpio_drive #(.PINS(PINS)) u_drive (
    .dir_q (dir_q),
    .oen_q (oen_q),
    .pin_oe(pin_oe)
  );

  assign pin_out = data_q;

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      sel_data: rdata = WORD_W'(data_q);
      sel_dir:  rdata = WORD_W'(dir_q);
      sel_oen:  rdata = WORD_W'(oen_q);
      sel_pins: rdata = WORD_W'(pins_sync);
      default:  rdata = '0;
    endcase
  end

  // R7
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0);
  // R7
  oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~oen_q) == '0);
  // R9
  dead_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dead_evt |=> ($stable(data_q) && $stable(dir_q) && $stable(oen_q)));
  // R9
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data_evt, wr_mlo_evt, wr_mhi_evt, wr_dir_evt, wr_oen_evt, wr_dead_evt}));
endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_data = '0, m_dir = '0, m_oen = '0;

  always #5 clk = ~clk;

  gpio_bank_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Bench restatement of the half-bank merge, bit by bit.
  function automatic logic [15:0] exp_half(input logic [15:0] old, input logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[16+i] ? old[i] : w[i];
    return r;
  endfunction

  function automatic logic [31:0] exp_oe(input logic [31:0] d, input logic [31:0] e);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (d[i] == 1'b1) && (e[i] == 1'b1);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_data = d;
      3'd1: m_data[15:0]  = exp_half(m_data[15:0], d);
      3'd2: m_data[31:16] = exp_half(m_data[31:16], d);
      3'd3: m_dir = d;
      3'd4: m_oen = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic full_check(input string tag);
    chk({tag, " pin_out"}, pin_out, m_data);
    chk("R7 pin_oe", pin_oe, exp_oe(m_dir, m_oen));
    rd_chk(3'd0, m_data, "R2 data readback");
    rd_chk(3'd3, m_dir, "R5 dir readback");
    rd_chk(3'd4, m_oen, "R6 enable readback");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    rd_chk(3'd0, 32'h0, "R1 data");
    rd_chk(3'd3, 32'h0, "R1 dir");
    rd_chk(3'd4, 32'h0, "R1 enable");

    // R2 full write
    bus_wr(3'd0, 32'hA5A5_0F0F);
    full_check("R2");
    // R3 all-zero mask overwrites low half; all-one mask keeps
    bus_wr(3'd1, 32'h0000_1234);
    full_check("R3 zero mask");
    bus_wr(3'd1, 32'hFFFF_FFFF);
    full_check("R3 full mask");
    // R4 same for high half
    bus_wr(3'd2, 32'h0000_BEEF);
    full_check("R4 zero mask");
    bus_wr(3'd2, 32'hFFFF_0000);
    full_check("R4 full mask");
    bus_wr(3'd2, 32'h00FF_FFFF);
    full_check("R4 partial");

    // R7 enable gating directed cases
    bus_wr(3'd3, 32'hFFFF_0000);
    bus_wr(3'd4, 32'hFF00_FF00);
    chk("R7 directed", pin_oe, 32'hFF00_0000);
    full_check("R7");

    // R9 dead writes
    for (int a = 5; a < 8; a++) begin
      bus_wr(3'(a), 32'hFFFF_FFFF);
      full_check("R9 dead write");
    end
    rd_chk(3'd1, 32'h0, "R9 read mlo");
    rd_chk(3'd2, 32'h0, "R9 read mhi");
    rd_chk(3'd6, 32'h0, "R9 read 6");
    rd_chk(3'd7, 32'h0, "R9 read 7");

    // R8 synchroniser latency
    for (int k = 0; k < 6; k++) begin
      logic [31:0] oldv, newv;
      oldv = pin_in;
      newv = (k == 0) ? 32'hFFFF_FFFF : $urandom;
      addr = 3'd5;
      @(negedge clk);
      pin_in = newv;
      @(negedge clk);
      #1 chk("R8 one edge", rdata, oldv);
      @(negedge clk);
      #1 chk("R8 two edges", rdata, newv);
    end

    // Random mix, R2 R3 R4 R5 R6
    for (int n = 0; n < 300; n++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom_range(0, 7));
      d = $urandom;
      if (($urandom % 4) == 0) d[31:16] = 16'h0;
      if (($urandom % 4) == 0) d[31:16] = 16'hFFFF;
      bus_wr(a, d);
      full_check("R3 R4 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule